// File: doc/BRIEF.md
# Shared Operand Bus Master

This block lets a processor core carry out one access at a time on a 16-bit operand bus that it shares with other processors and direct-memory-access devices. When the core requests an access, the block pulls its bus request low. It then waits until the grant it receives on the falling clock edge shows that the previous owner has let go of the bus. At that point it takes ownership and runs the access phase. Address, write data, the memory/IO select and the read/write line become valid together with the grant acknowledge. The data strobe follows one clock later.

The responding device adds wait states by holding its acknowledge high. The access ends on the first rising edge on which the acknowledge is low, or earlier if a bus-timer error or a memory-protect violation is signalled. Each error is sent to its own fault flag, so a fault register next to the block can tell the sources apart. Whenever the block does not own the bus, it releases every shared line to high impedance. One done pulse returns the result to the core.

Top module: `opb_master`

## Requirements
- R1: During and right after reset, bus_req_n_o and bus_gack_n_o are high, done_o is low, fault_o is zero and all shared bus lines are released.
- R2: bus_req_n_o goes low in the cycle after start_i is sampled. bus_gack_n_o goes low only on the rising edge that follows a falling edge on which bus_busy_n_i was high and bus_grant_n_i was low. It never goes low while another master holds bus_busy_n_i low.
- R3: Address, write data (for writes), bus_io_o (1 = I/O space) and bus_write_o (1 = write) are valid in the cycle where bus_gack_n_o falls. bus_strobe_n_o falls exactly one cycle later.
- R4: After the strobe falls, bus_ack_n_i is sampled on every rising edge. With the acknowledge first low in strobe cycle w+1, done_o rises w+1 cycles after the strobe fell.
- R5: On a read that ends without error, rdata_o holds the bus data sampled on the edge where the acknowledge was seen low, and done_o rises with err_o low.
- R6: An active-low bus-timer or protect error during the owned phase ends the access with err_o high and leaves rdata_o unchanged. An error wins over an acknowledge that arrives on the same edge.
- R7: When the block is not master, bus_addr_o, bus_data_io, bus_io_o, bus_write_o and bus_strobe_n_o are high impedance, and another driver's values are visible on them.
- R8: bus_prot_n_i low while the block is master pulses fault_o bit 0 (processor protect). Low while it is not master, it pulses fault_o bit 1 (DMA protect).
- R9: bus_tmo_n_i low while master pulses fault_o bit 2 for a memory access or bit 3 for an I/O access. Low while not master, it has no effect.
- R10: In the done_o cycle, request, acknowledge and strobe are all high again, and done_o lasts exactly one cycle.
- R11: A start_i while an access is in progress is ignored. No second request follows the current access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Core access request, sampled when idle |
| write_i | input | 1 | 1 = write access |
| io_i | input | 1 | 1 = I/O space, 0 = memory |
| addr_i | input | 16 | Access address |
| wdata_i | input | 16 | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Access ended by an error (valid with done_o) |
| rdata_o | output | 16 | Captured read data |
| fault_o | output | 4 | Fault set pulses: 0 cpu protect, 1 dma protect, 2 memory timer, 3 I/O timer |
| bus_req_n_o | output | 1 | Bus request, active low |
| bus_grant_n_i | input | 1 | Bus grant from arbiter, active low |
| bus_busy_n_i | input | 1 | Bus busy, low while another master owns the bus |
| bus_gack_n_o | output | 1 | Grant acknowledge, active low |
| bus_addr_o | output | 16 | Shared address, tri-state |
| bus_data_io | inout | 16 | Shared data, tri-state |
| bus_io_o | output | 1 | Memory/IO select, tri-state |
| bus_write_o | output | 1 | Read/write line, tri-state |
| bus_strobe_n_o | output | 1 | Data strobe, active low, tri-state |
| bus_ack_n_i | input | 1 | Data transfer acknowledge, active low |
| bus_tmo_n_i | input | 1 | Bus timer error, active low |
| bus_prot_n_i | input | 1 | Memory protect violation, active low |

## Verification
A stuck or wrong phase shows on the shared lines at once. A missing strobe or acknowledge, or a strobe without the one-cycle setup after the acknowledge, appears in the first owned cycle. A phase that fails to return to idle keeps the bus driven and the request low. A wrong latch of the space bit or of the owned flag shows up in the next cycle as a fault pulse on the wrong bit. A read-data register that a failed access has overwritten differs from the value of the last good read on the same done pulse.

// File: rtl/opb_pkg.sv
package opb_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REQ  = 2'd1,
        PH_ADDR = 2'd2,
        PH_STRB = 2'd3
    } phase_e;

    localparam int FAULT_W      = 4;
    localparam int FLT_CPU_PROT = 0;
    localparam int FLT_DMA_PROT = 1;
    localparam int FLT_MEM_TMO  = 2;
    localparam int FLT_IO_TMO   = 3;
endpackage

// File: rtl/opb_grant_sampler.sv
module opb_grant_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_n_i,
    input  logic grant_n_i,
    output logic won_o
);
    logic won_d, won_q;

    always_comb begin
        won_d = busy_n_i & ~grant_n_i;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) won_q <= 1'b0;
        else        won_q <= won_d;
    end

    assign won_o = won_q;
endmodule

// File: rtl/opb_fault_log.sv
module opb_fault_log
    import opb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               master_i,
    input  logic               io_i,
    input  logic               prot_n_i,
    input  logic               tmo_n_i,
    output logic [FAULT_W-1:0] fault_o
);
    logic [FAULT_W-1:0] fault_d, fault_q;

    always_comb begin
        fault_d               = '0;
        fault_d[FLT_CPU_PROT] = master_i & ~prot_n_i;
        fault_d[FLT_DMA_PROT] = ~master_i & ~prot_n_i;
        fault_d[FLT_MEM_TMO]  = master_i & ~io_i & ~tmo_n_i;
        fault_d[FLT_IO_TMO]   = master_i & io_i & ~tmo_n_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_q <= '0;
        else        fault_q <= fault_d;
    end

    assign fault_o = fault_q;

    // R8
    prot_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fault_q[FLT_DMA_PROT:FLT_CPU_PROT]));
    // R9
    tmo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fault_q[FLT_IO_TMO:FLT_MEM_TMO]));
    // R9
    tmo_needs_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q[FLT_MEM_TMO] || fault_q[FLT_IO_TMO]) |-> $past(master_i));
endmodule

// File: rtl/opb_seq.sv
module opb_seq
    import opb_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          write_i,
    input  logic          io_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          won_i,
    input  logic          ack_n_i,
    input  logic          tmo_n_i,
    input  logic          prot_n_i,
    input  logic [DW-1:0] rd_bus_i,
    output logic          master_o,
    output logic          io_o,
    output logic          write_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic          req_n_o,
    output logic          gack_n_o,
    output logic          strb_n_o,
    output logic          done_o,
    output logic          err_o,
    output logic [DW-1:0] rdata_o
);
    typedef struct packed {
        phase_e        ph;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          wr;
        logic          io;
        logic [DW-1:0] rdata;
        logic          done;
        logic          err;
    } seq_t;

    seq_t s_d, s_q;
    logic err_hit;

    always_comb begin
        err_hit  = ~tmo_n_i | ~prot_n_i;
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.ph    = PH_REQ;
                    s_d.addr  = addr_i;
                    s_d.wdata = wdata_i;
                    s_d.wr    = write_i;
                    s_d.io    = io_i;
                end
            end
            PH_REQ: begin
                if (won_i) s_d.ph = PH_ADDR;
            end
            PH_ADDR: begin
                if (err_hit) begin
                    s_d.ph   = PH_IDLE;
                    s_d.done = 1'b1;
                    s_d.err  = 1'b1;
                end else begin
                    s_d.ph = PH_STRB;
                end
            end
            PH_STRB: begin
                if (err_hit) begin
                    s_d.ph   = PH_IDLE;
                    s_d.done = 1'b1;
                    s_d.err  = 1'b1;
                end else if (!ack_n_i) begin
                    s_d.ph   = PH_IDLE;
                    s_d.done = 1'b1;
                    s_d.err  = 1'b0;
                    if (!s_q.wr) s_d.rdata = rd_bus_i;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign master_o = (s_q.ph == PH_ADDR) || (s_q.ph == PH_STRB);
    assign io_o     = s_q.io;
    assign write_o  = s_q.wr;
    assign addr_o   = s_q.addr;
    assign wdata_o  = s_q.wdata;
    assign req_n_o  = (s_q.ph == PH_IDLE);
    assign gack_n_o = ~master_o;
    assign strb_n_o = (s_q.ph != PH_STRB);
    assign done_o   = s_q.done;
    assign err_o    = s_q.err;
    assign rdata_o  = s_q.rdata;

    // R2
    gack_after_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gack_n_o) |-> $past(won_i));
    // R3
    strobe_after_gack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strb_n_o) |-> $past(!gack_n_o) && !gack_n_o);
    // R10
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (req_n_o && gack_n_o && strb_n_o));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R6
    rdata_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> $stable(rdata_o));
endmodule

// File: rtl/opb_master.sv
module opb_master
    import opb_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               write_i,
    input  logic               io_i,
    input  logic [AW-1:0]      addr_i,
    input  logic [DW-1:0]      wdata_i,
    output logic               done_o,
    output logic               err_o,
    output logic [DW-1:0]      rdata_o,
    output logic [FAULT_W-1:0] fault_o,
    output logic               bus_req_n_o,
    input  logic               bus_grant_n_i,
    input  logic               bus_busy_n_i,
    output logic               bus_gack_n_o,
    output logic [AW-1:0]      bus_addr_o,
    inout  wire  [DW-1:0]      bus_data_io,
    output logic               bus_io_o,
    output logic               bus_write_o,
    output logic               bus_strobe_n_o,
    input  logic               bus_ack_n_i,
    input  logic               bus_tmo_n_i,
    input  logic               bus_prot_n_i
);
    logic          won;
    logic          master;
    logic          io_q;
    logic          wr_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          strb_n;

    opb_grant_sampler u_samp (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy_n_i  (bus_busy_n_i),
        .grant_n_i (bus_grant_n_i),
        .won_o     (won)
    );

    opb_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .write_i  (write_i),
        .io_i     (io_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .won_i    (won),
        .ack_n_i  (bus_ack_n_i),
        .tmo_n_i  (bus_tmo_n_i),
        .prot_n_i (bus_prot_n_i),
        .rd_bus_i (bus_data_io),
        .master_o (master),
        .io_o     (io_q),
        .write_o  (wr_q),
        .addr_o   (addr_q),
        .wdata_o  (wdata_q),
        .req_n_o  (bus_req_n_o),
        .gack_n_o (bus_gack_n_o),
        .strb_n_o (strb_n),
        .done_o   (done_o),
        .err_o    (err_o),
        .rdata_o  (rdata_o)
    );

    opb_fault_log u_flt (
        .clk      (clk),
        .rst_n    (rst_n),
        .master_i (master),
        .io_i     (io_q),
        .prot_n_i (bus_prot_n_i),
        .tmo_n_i  (bus_tmo_n_i),
        .fault_o  (fault_o)
    );

    assign bus_addr_o     = master ? addr_q : 'z;
    assign bus_io_o       = master ? io_q   : 1'bz;
    assign bus_write_o    = master ? wr_q   : 1'bz;
    assign bus_strobe_n_o = master ? strb_n : 1'bz;
    assign bus_data_io    = (master && wr_q) ? wdata_q : 'z;
endmodule

// File: tb/opb_master_test.sv
module opb_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;

    typedef struct packed {
        logic        wr;
        logic        io;
        logic [1:0]  errk;   // 0 none, 1 timer, 2 protect, 3 ack+timer
        logic [3:0]  gdel;
        logic [3:0]  hold;
        logic [3:0]  waits;
        logic        poke;
        logic [15:0] addr;
        logic [15:0] wdata;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 2'd0, 4'd0, 4'd0, 4'd0, 1'b0, 16'h1234, 16'h0000},
        '{1'b1, 1'b0, 2'd0, 4'd2, 4'd0, 4'd3, 1'b0, 16'h00F0, 16'hA5A5},
        '{1'b0, 1'b1, 2'd0, 4'd1, 4'd0, 4'd1, 1'b0, 16'h0040, 16'h0000},
        '{1'b0, 1'b0, 2'd1, 4'd0, 4'd0, 4'd2, 1'b0, 16'h2222, 16'h0000},
        '{1'b1, 1'b1, 2'd1, 4'd0, 4'd0, 4'd0, 1'b0, 16'h0011, 16'h5A5A},
        '{1'b0, 1'b0, 2'd2, 4'd1, 4'd0, 4'd1, 1'b0, 16'h3333, 16'h0000},
        '{1'b0, 1'b0, 2'd3, 4'd0, 4'd0, 4'd0, 1'b0, 16'h4444, 16'h0000},
        '{1'b0, 1'b0, 2'd0, 4'd0, 4'd6, 4'd5, 1'b1, 16'hABCD, 16'h0000},
        '{1'b1, 1'b0, 2'd0, 4'd3, 4'd1, 4'd2, 1'b0, 16'h7777, 16'h0F0F}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, wr = 1'b0, io = 1'b0;
    logic [15:0] addr = '0, wdata = '0;
    logic done, err;
    logic [15:0] rdata;
    logic [3:0] fault;
    logic req_n, gack_n;
    logic grant_n = 1'b1, busy_n = 1'b1;
    logic ack_n = 1'b1, tmo_n = 1'b1, prot_n = 1'b1;
    logic dma_drv = 1'b0, mem_drv = 1'b0;
    logic [15:0] mem_val = '0;

    wire [15:0] addr_bus;
    wire [15:0] data_bus;
    wire        io_bus, wr_bus, strb_bus;

    assign addr_bus = dma_drv ? 16'hBEEF : 'z;
    assign data_bus = dma_drv ? 16'hBEEF : (mem_drv ? mem_val : 'z);
    assign io_bus   = dma_drv ? 1'b1 : 1'bz;
    assign wr_bus   = dma_drv ? 1'b1 : 1'bz;
    assign strb_bus = dma_drv ? 1'b0 : 1'bz;

    int checks = 0;
    int errors = 0;
    logic [15:0] last_good = '0;

    opb_master uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .write_i(wr), .io_i(io),
        .addr_i(addr), .wdata_i(wdata), .done_o(done), .err_o(err),
        .rdata_o(rdata), .fault_o(fault), .bus_req_n_o(req_n),
        .bus_grant_n_i(grant_n), .bus_busy_n_i(busy_n), .bus_gack_n_o(gack_n),
        .bus_addr_o(addr_bus), .bus_data_io(data_bus), .bus_io_o(io_bus),
        .bus_write_o(wr_bus), .bus_strobe_n_o(strb_bus), .bus_ack_n_i(ack_n),
        .bus_tmo_n_i(tmo_n), .bus_prot_n_i(prot_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_xfer(input vec_t v);
        int req_cnt = 0, s = 0, gack_at = -1, strb_at = -1, win_at = -1, done_at = -1;
        logic [3:0] exp_f;
        start = 1'b1; wr = v.wr; io = v.io; addr = v.addr; wdata = v.wdata;
        busy_n = (v.hold == 0);
        tick();
        start = 1'b0;
        // R2: request follows the sampled start
        chk(req_n == 1'b0, "R2 req", {31'd0, req_n}, 32'd0);
        for (int it = 0; it < 80 && done_at < 0; it++) begin
            if (it > 0) tick();
            start = 1'b0;
            if (done) begin
                done_at = it;
            end else begin
                if (gack_n == 1'b0 && gack_at < 0) begin
                    gack_at = it;
                    // R2: acknowledge exactly one cycle after the winning grant
                    chk(gack_at == win_at + 1, "R2 gack timing", gack_at, win_at + 1);
                    // R3: address phase contents
                    chk(addr_bus == v.addr && io_bus == v.io && wr_bus == v.wr && strb_bus == 1'b1,
                        "R3 addr phase", {addr_bus, 13'd0, io_bus, wr_bus, strb_bus},
                        {v.addr, 13'd0, v.io, v.wr, 1'b1});
                    if (v.wr) chk(data_bus == v.wdata, "R3 wdata", data_bus, v.wdata);
                end
                if (strb_bus == 1'b0 && gack_at >= 0) begin
                    if (strb_at < 0) begin
                        strb_at = it;
                        chk(strb_at == gack_at + 1, "R3 strobe delay", strb_at, gack_at + 1);
                        if (v.poke) start = 1'b1;
                    end
                    s++;
                    mem_drv = !v.wr;
                    mem_val = ~v.addr;
                    if (s == v.waits + 1) begin
                        case (v.errk)
                            2'd0: ack_n = 1'b0;
                            2'd1: tmo_n = 1'b0;
                            2'd2: prot_n = 1'b0;
                            default: begin ack_n = 1'b0; tmo_n = 1'b0; end
                        endcase
                    end
                end
                if (req_n == 1'b0 && gack_n == 1'b1) begin
                    if (req_cnt == v.gdel) grant_n = 1'b0;
                    if (req_cnt == v.hold) busy_n = 1'b1;
                    if (win_at < 0 && grant_n == 1'b0 && busy_n == 1'b1) win_at = it;
                    if (win_at < 0 && gack_at >= 0) win_at = -5;
                    req_cnt++;
                end
            end
        end
        ack_n = 1'b1; tmo_n = 1'b1; prot_n = 1'b1; grant_n = 1'b1; busy_n = 1'b1; mem_drv = 1'b0;
        // R4: done latency after strobe
        chk(done_at >= 0 && done_at - strb_at == v.waits + 1, "R4 wait states",
            done_at - strb_at, v.waits + 1);
        // R10: released in the done cycle
        chk(req_n && gack_n, "R10 release", {30'd0, req_n, gack_n}, 32'd3);
        exp_f = 4'd0;
        if (v.errk == 2'd2) exp_f = 4'b0001;
        else if (v.errk != 2'd0) exp_f = v.io ? 4'b1000 : 4'b0100;
        // R8 R9: fault routing
        chk(fault == exp_f, "R8/R9 fault bits", fault, exp_f);
        // R6: error flag; R5: read data
        chk(err == (v.errk != 2'd0), "R6 err flag", err, v.errk != 2'd0);
        if (v.errk == 2'd0 && !v.wr) last_good = ~v.addr;
        chk(rdata == last_good, "R5 R6 rdata", rdata, last_good);
        tick();
        chk(done == 1'b0, "R10 done pulse", done, 0);
        if (v.poke) begin
            // R11: poked start ignored
            chk(req_n == 1'b1, "R11 ignored start", req_n, 1);
            tick();
            chk(req_n == 1'b1, "R11 ignored start", req_n, 1);
        end
        tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(req_n && gack_n && !done && fault == 4'd0, "R1 reset",
            {req_n, gack_n, done, fault}, 7'b1100000);
        dma_drv = 1'b1;
        #1;
        // R7: lines float in reset
        chk(addr_bus == 16'hBEEF && data_bus == 16'hBEEF && strb_bus == 1'b0,
            "R7 float reset", addr_bus, 16'hBEEF);
        dma_drv = 1'b0;
        rst_n = 1'b1;
        tick();
        chk(req_n && gack_n && !done, "R1 after reset", {req_n, gack_n, done}, 3'b110);

        for (int i = 0; i < NV; i++) do_xfer(VECS[i]);

        // R7: idle float while another master drives
        dma_drv = 1'b1;
        #1;
        chk(addr_bus == 16'hBEEF && data_bus == 16'hBEEF && io_bus && wr_bus && !strb_bus,
            "R7 float idle", {addr_bus, data_bus}, 32'hBEEFBEEF);
        // R8: protect while not master goes to DMA flag
        prot_n = 1'b0;
        tick();
        prot_n = 1'b1;
        chk(fault == 4'b0010, "R8 dma protect", fault, 4'b0010);
        tick();
        chk(fault == 4'b0000, "R8 pulse end", fault, 4'b0000);
        // R9: timer error while idle ignored
        tmo_n = 1'b0;
        tick();
        chk(fault == 4'b0000 && !done, "R9 idle timer", fault, 4'b0000);
        tick();
        tmo_n = 1'b1;
        chk(fault == 4'b0000 && req_n, "R9 idle timer", fault, 4'b0000);
        dma_drv = 1'b0;
        tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule